// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block owns the command pins of a four-bank double-data-rate SDRAM from reset until the memory can accept normal traffic. After reset it keeps the clock enable low and the device deselected for a programmable settling time. It then raises the clock enable, waits one idle cycle and plays a fixed bring-up program: close every bank, program the extended mode register with the DLL turned on, program the base mode register with the DLL-reset bit set, issue two auto refreshes, and program the base mode register a second time with the DLL-reset bit cleared. It then raises a done flag and drives idle commands for as long as reset stays high.

Every spacing between two commands is a parameter counted in clock cycles, as are the burst-length and CAS-latency codes written into the mode register. A code that names no legal setting is replaced by a safe default, so a bad build parameter can never put an undefined value into the device. All outputs come straight from flops. The reset is asynchronous on assertion and is released through a synchronizer.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is low, and for at least STAB_CYC cycles after it is released, `cke` is 0 and `cs_n` is 1 with `ras_n`, `cas_n` and `we_n` at 1. `init_done` is 0 during reset.
- R2: Once `cke` rises it stays high. At least one cycle with no command (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1) separates the rise of `cke` from the first command.
- R3: The commands appear in this exact order: precharge, extended mode load, base mode load, auto refresh, auto refresh, base mode load. Each command has `cs_n`=0, with {`ras_n`,`cas_n`,`we_n`} at 010 for precharge, 001 for auto refresh and 000 for a mode load.
- R4: The precharge closes all banks. `addr[10]` is 1 and every other address bit is 0.
- R5: The extended mode load uses `ba`=01 with an all-zero address, so address bit 0 is 0 and the DLL is enabled. Both base mode loads use `ba`=00.
- R6: The base mode word carries the burst-length code in bits [2:0] (001=2, 010=4, 011=8) and the CAS-latency code in bits [6:4] (010=2, 110=2.5, 011=3). Bit 3 is 0. Bit 8 (DLL reset) is 1 in the first base load and 0 in the second. All other bits are 0.
- R7: A burst-length code outside {001,010,011} is replaced by 010. A CAS-latency code outside {010,110,011} is replaced by 010. Each field is handled on its own.
- R8: The distance between command cycles is exactly TRP_CYC from the precharge to the extended load, and TMRD_CYC from the extended load to the first base load. It is also TMRD_CYC from that base load to the first refresh. It is TRC_CYC between the two refreshes and from the second refresh to the final base load.
- R9: `init_done` rises exactly TMRD_CYC cycles after the final base mode load and then stays high. While it is high, only the no-command pattern is driven.
- R10: No mode load and no auto refresh is issued before a precharge of all banks has been issued since reset.
- R11: Pulling `rst_n` low at any point returns every output to its reset value at once. After the release, the whole program restarts from the settling period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus (mode word during mode loads) |
| init_done | output | 1 | Bring-up finished |

## Verification
The bench measures the exact distance between every pair of commands. A design that confuses the load value of its gap counter with the gap itself gives spacings one cycle short or long, and the bench sees this at each of the five gaps. It decodes the mode words for a legal configuration with the half-cycle CAS latency and for an instance built with illegal codes. A design that does not replace bad codes, or that writes the DLL-reset bit in the wrong load, shows a wrong address word there. It also pulls reset low in the middle of the program. A design whose output flops are not reset asynchronously, or that resumes where it stopped instead of restarting, shows stale outputs or a shortened command list.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_IDLE,
    CMD_CLOSE_ALL,
    CMD_LOAD_EXT,
    CMD_LOAD_BASE_RST,
    CMD_REFRESH,
    CMD_LOAD_BASE
  } init_cmd_e;

  localparam logic [2:0] BL_FALLBACK = 3'b010;
  localparam logic [2:0] CL_FALLBACK = 3'b010;

  function automatic logic [2:0] legal_bl(input logic [2:0] code);
    if (code == 3'b001 || code == 3'b010 || code == 3'b011) return code;
    return BL_FALLBACK;
  endfunction

  function automatic logic [2:0] legal_cl(input logic [2:0] code);
    if (code == 3'b010 || code == 3'b110 || code == 3'b011) return code;
    return CL_FALLBACK;
  endfunction

endpackage

// File: rtl/ddr_init_rst_sync.sv
module ddr_init_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int STAB_CYC = 200,
  parameter int TRP_CYC  = 3,
  parameter int TMRD_CYC = 2,
  parameter int TRC_CYC  = 10
) (
  input  logic      clk,
  input  logic      rst_n,
  output init_cmd_e cmd,
  output logic      cke_on,
  output logic      done
);

  // gaps below two cycles cannot be produced by the issue/gap pair
  localparam int STAB_E  = (STAB_CYC < 1) ? 1 : STAB_CYC;
  localparam int TRP_E   = (TRP_CYC  < 2) ? 2 : TRP_CYC;
  localparam int TMRD_E  = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int TRC_E   = (TRC_CYC  < 2) ? 2 : TRC_CYC;
  localparam int MAX_A   = (STAB_E > TRP_E) ? STAB_E : TRP_E;
  localparam int MAX_B   = (TMRD_E > TRC_E) ? TMRD_E : TRC_E;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int NUM_STEPS = 6;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_WAKE,
    ST_ISSUE,
    ST_GAP,
    ST_READY
  } seq_state_e;

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en, step_en;

  init_cmd_e         step_cmd;
  logic [CNT_W-1:0]  step_gap;

  // program table: command and following gap for each step
  always_comb begin
    case (step_q)
      STEP_W'(0): begin step_cmd = CMD_CLOSE_ALL;     step_gap = CNT_W'(TRP_E);  end
      STEP_W'(1): begin step_cmd = CMD_LOAD_EXT;      step_gap = CNT_W'(TMRD_E); end
      STEP_W'(2): begin step_cmd = CMD_LOAD_BASE_RST; step_gap = CNT_W'(TMRD_E); end
      STEP_W'(3): begin step_cmd = CMD_REFRESH;       step_gap = CNT_W'(TRC_E);  end
      STEP_W'(4): begin step_cmd = CMD_REFRESH;       step_gap = CNT_W'(TRC_E);  end
      default:    begin step_cmd = CMD_LOAD_BASE;     step_gap = CNT_W'(TMRD_E); end
    endcase
  end

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    step_en = 1'b0;
    case (state_q)
      ST_SETTLE: begin
        if (cnt_q == '0) begin
          state_d = ST_WAKE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_WAKE: begin
        state_d = ST_ISSUE;
        step_d  = '0;
        step_en = 1'b1;
      end
      ST_ISSUE: begin
        cnt_d   = step_gap - 1'b1;
        cnt_en  = 1'b1;
        state_d = ST_GAP;
      end
      ST_GAP: begin
        if (cnt_q == CNT_W'(1)) begin
          if (step_q == LAST_STEP) begin
            state_d = ST_READY;
          end else begin
            state_d = ST_ISSUE;
            step_d  = step_q + 1'b1;
            step_en = 1'b1;
          end
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SETTLE;
      step_q  <= '0;
      cnt_q   <= CNT_W'(STAB_E - 1);
    end else begin
      state_q <= state_d;
      if (step_en) step_q <= step_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_SETTLE: cmd = CMD_DESEL;
      ST_ISSUE:  cmd = step_cmd;
      default:   cmd = CMD_IDLE;
    endcase
  end

  assign cke_on = (state_q != ST_SETTLE);
  assign done   = (state_q == ST_READY);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int         ADDR_W     = 13,
  parameter int         BA_W       = 2,
  parameter logic [2:0] BL_CODE    = 3'b010,
  parameter logic [2:0] CL_CODE    = 3'b010,
  parameter int         AP_BIT     = 10,
  parameter int         DLLRST_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  init_cmd_e         cmd,
  input  logic              cke_on,
  input  logic              done,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam logic [2:0] BL_L = legal_bl(BL_CODE);
  localparam logic [2:0] CL_L = legal_cl(CL_CODE);

  function automatic logic [ADDR_W-1:0] mode_word(input logic dll_rst);
    logic [ADDR_W-1:0] w;
    w             = '0;
    w[2:0]        = BL_L;
    w[6:4]        = CL_L;
    w[DLLRST_BIT] = dll_rst;
    return w;
  endfunction

  logic              cs_d, ras_d, cas_d, we_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cs_d   = 1'b0;
    ras_d  = 1'b1;
    cas_d  = 1'b1;
    we_d   = 1'b1;
    ba_d   = '0;
    addr_d = '0;
    case (cmd)
      CMD_DESEL: cs_d = 1'b1;
      CMD_CLOSE_ALL: begin
        ras_d          = 1'b0;
        we_d           = 1'b0;
        addr_d[AP_BIT] = 1'b1;
      end
      CMD_LOAD_EXT: begin
        ras_d = 1'b0;
        cas_d = 1'b0;
        we_d  = 1'b0;
        ba_d  = BA_W'(1);
      end
      CMD_LOAD_BASE_RST: begin
        ras_d  = 1'b0;
        cas_d  = 1'b0;
        we_d   = 1'b0;
        addr_d = mode_word(1'b1);
      end
      CMD_REFRESH: begin
        ras_d = 1'b0;
        cas_d = 1'b0;
      end
      CMD_LOAD_BASE: begin
        ras_d  = 1'b0;
        cas_d  = 1'b0;
        we_d   = 1'b0;
        addr_d = mode_word(1'b0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke       <= 1'b0;
      cs_n      <= 1'b1;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      ba        <= '0;
      addr      <= '0;
      init_done <= 1'b0;
    end else begin
      cke       <= cke_on;
      cs_n      <= cs_d;
      ras_n     <= ras_d;
      cas_n     <= cas_d;
      we_n      <= we_d;
      ba        <= ba_d;
      addr      <= addr_d;
      init_done <= done;
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int         ADDR_W   = 13,
  parameter int         BA_W     = 2,
  parameter int         STAB_CYC = 200,
  parameter int         TRP_CYC  = 3,
  parameter int         TMRD_CYC = 2,
  parameter int         TRC_CYC  = 10,
  parameter logic [2:0] BL_CODE  = 3'b010,
  parameter logic [2:0] CL_CODE  = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  logic      rst_n_int;
  init_cmd_e cmd;
  logic      cke_on;
  logic      done;

  ddr_init_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ddr_init_fsm #(
    .STAB_CYC (STAB_CYC),
    .TRP_CYC  (TRP_CYC),
    .TMRD_CYC (TMRD_CYC),
    .TRC_CYC  (TRC_CYC)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .cmd    (cmd),
    .cke_on (cke_on),
    .done   (done)
  );

  ddr_init_cmd_enc #(
    .ADDR_W  (ADDR_W),
    .BA_W    (BA_W),
    .BL_CODE (BL_CODE),
    .CL_CODE (CL_CODE)
  ) u_enc (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmd       (cmd),
    .cke_on    (cke_on),
    .done      (done),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
  );

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int TMRD_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  logic is_ml, is_pre, is_ref, is_idle;
  assign is_ml   = !cs_n && !ras_n && !cas_n && !we_n;
  assign is_pre  = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_ref  = !cs_n && !ras_n && !cas_n &&  we_n;
  assign is_idle = !cs_n &&  ras_n &&  cas_n &&  we_n;

  logic        pre_seen_q, ml_seen_q;
  logic [15:0] since_ml_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_seen_q <= 1'b0;
      ml_seen_q  <= 1'b0;
      since_ml_q <= '0;
    end else begin
      if (is_pre && addr[10]) pre_seen_q <= 1'b1;
      if (is_ml) begin
        ml_seen_q  <= 1'b1;
        since_ml_q <= 16'd1;
      end else if (since_ml_q != 16'hFFFF) begin
        since_ml_q <= since_ml_q + 16'd1;
      end
    end
  end

  a_r1_deselect_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cs_n);

  a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  a_r4_precharge_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> addr[10]);

  a_r5_mode_bank: assert property (@(posedge clk) disable iff (!rst_n)
    is_ml |-> (ba[BA_W-1:1] == '0) && (ba[0] == 1'b0 || addr == '0));

  a_r8_mrd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ml && ml_seen_q) |-> (since_ml_q >= 16'(TMRD_CYC)));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_idle);

  a_r10_precharged_first: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ml || is_ref) |-> pre_seen_q);

endmodule

bind ddr_init_seq ddr_init_chk #(
  .ADDR_W   (ADDR_W),
  .BA_W     (BA_W),
  .TMRD_CYC (TMRD_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;

  localparam int STAB = 20;
  localparam int TRP  = 4;
  localparam int TMRD = 3;
  localparam int TRC  = 9;

  logic clk;
  logic rst_n;

  wire [1:0]  w_cke, w_cs, w_ras, w_cas, w_we, w_done;
  wire [1:0]  w_ba   [2];
  wire [12:0] w_addr [2];

  ddr_init_seq #(
    .ADDR_W(13), .BA_W(2), .STAB_CYC(STAB), .TRP_CYC(TRP), .TMRD_CYC(TMRD),
    .TRC_CYC(TRC), .BL_CODE(3'b011), .CL_CODE(3'b110)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cke(w_cke[0]), .cs_n(w_cs[0]), .ras_n(w_ras[0]),
    .cas_n(w_cas[0]), .we_n(w_we[0]), .ba(w_ba[0]), .addr(w_addr[0]),
    .init_done(w_done[0])
  );

  ddr_init_seq #(
    .ADDR_W(13), .BA_W(2), .STAB_CYC(STAB), .TRP_CYC(TRP), .TMRD_CYC(TMRD),
    .TRC_CYC(TRC), .BL_CODE(3'b111), .CL_CODE(3'b001)
  ) dut_ill (
    .clk(clk), .rst_n(rst_n), .cke(w_cke[1]), .cs_n(w_cs[1]), .ras_n(w_ras[1]),
    .cas_n(w_cas[1]), .we_n(w_we[1]), .ba(w_ba[1]), .addr(w_addr[1]),
    .init_done(w_done[1])
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // port monitor
  int         cyc = 0;
  logic [2:0] lg_cmd  [2][8];
  logic [1:0] lg_ba   [2][8];
  logic [12:0] lg_addr [2][8];
  int         lg_cyc  [2][8];
  int         lg_n    [2];
  int         low_cnt [2];
  int         rise_cyc[2];
  int         done_cyc[2];
  int         bad_after[2];

  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        lg_n[i] = 0; low_cnt[i] = 0; rise_cyc[i] = -1;
        done_cyc[i] = -1; bad_after[i] = 0;
      end else begin
        if (!w_cke[i]) low_cnt[i]++;
        else if (rise_cyc[i] < 0) rise_cyc[i] = cyc;
        if (!w_cs[i] && {w_ras[i], w_cas[i], w_we[i]} != 3'b111) begin
          if (lg_n[i] < 8) begin
            lg_cmd[i][lg_n[i]]  = {w_ras[i], w_cas[i], w_we[i]};
            lg_ba[i][lg_n[i]]   = w_ba[i];
            lg_addr[i][lg_n[i]] = w_addr[i];
            lg_cyc[i][lg_n[i]]  = cyc;
          end
          lg_n[i]++;
        end
        if (w_done[i]) begin
          if (done_cyc[i] < 0) done_cyc[i] = cyc;
          if (w_cs[i] || {w_ras[i], w_cas[i], w_we[i]} != 3'b111) bad_after[i]++;
        end else if (done_cyc[i] >= 0) begin
          bad_after[i]++;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_mode(input int bl, input int cl, input int dll_rst);
    return (dll_rst << 8) | (cl << 4) | bl;
  endfunction

  localparam logic [2:0] C_PRE = 3'b010, C_ML = 3'b000, C_REF = 3'b001;

  task automatic wait_done(input int i);
    for (int k = 0; k < 3000 && !w_done[i]; k++) @(negedge clk);
    #1;
    chk("R9", "done reached", int'(w_done[i]), 1);
  endtask

  task automatic check_reset_outputs(input string req);
    chk(req, "cke in reset", int'(w_cke[0]), 0);
    chk(req, "cs_n in reset", int'(w_cs[0]), 1);
    chk(req, "ras/cas/we in reset", int'({w_ras[0], w_cas[0], w_we[0]}), 7);
    chk(req, "done in reset", int'(w_done[0]), 0);
  endtask

  task automatic test_reset_state;
    repeat (4) @(negedge clk);
    #1;
    check_reset_outputs("R1");
  endtask

  task automatic test_settle;
    chk("R1", "cke low at least STAB", int'(low_cnt[0] >= STAB), 1);
    chk("R1", "cke low bounded", int'(low_cnt[0] <= STAB + 5), 1);
    chk("R2", "idle cycle before first cmd", int'(lg_cyc[0][0] - rise_cyc[0] >= 1), 1);
  endtask

  task automatic check_order(input int i, input string tag);
    logic [2:0] e [6];
    e[0] = C_PRE; e[1] = C_ML; e[2] = C_ML; e[3] = C_REF; e[4] = C_REF; e[5] = C_ML;
    chk("R3", {tag, " command count"}, lg_n[i], 6);
    for (int k = 0; k < 6; k++) chk("R3", $sformatf("%s cmd %0d", tag, k), int'(lg_cmd[i][k]), int'(e[k]));
  endtask

  task automatic test_banks;
    chk("R4", "precharge addr", int'(lg_addr[0][0]), 32'h400);
    chk("R5", "ext load bank", int'(lg_ba[0][1]), 1);
    chk("R5", "ext load addr (DLL on)", int'(lg_addr[0][1]), 0);
    chk("R5", "base load 1 bank", int'(lg_ba[0][2]), 0);
    chk("R5", "base load 2 bank", int'(lg_ba[0][5]), 0);
  endtask

  task automatic test_mode_words;
    chk("R6", "first base word", int'(lg_addr[0][2]), exp_mode(3, 6, 1));
    chk("R6", "second base word", int'(lg_addr[0][5]), exp_mode(3, 6, 0));
  endtask

  task automatic test_spacing;
    chk("R8", "pre to ext", lg_cyc[0][1] - lg_cyc[0][0], TRP);
    chk("R8", "ext to base", lg_cyc[0][2] - lg_cyc[0][1], TMRD);
    chk("R8", "base to ref", lg_cyc[0][3] - lg_cyc[0][2], TMRD);
    chk("R8", "ref to ref", lg_cyc[0][4] - lg_cyc[0][3], TRC);
    chk("R8", "ref to base", lg_cyc[0][5] - lg_cyc[0][4], TRC);
  endtask

  task automatic test_done_hold;
    chk("R9", "done delay", done_cyc[0] - lg_cyc[0][5], TMRD);
    repeat (40) @(negedge clk);
    #1;
    chk("R9", "done still high", int'(w_done[0]), 1);
    chk("R9", "only idle after done", bad_after[0], 0);
    chk("R9", "no extra commands", lg_n[0], 6);
  endtask

  task automatic test_illegal;
    check_order(1, "illegal-code");
    chk("R7", "fallback word 1", int'(lg_addr[1][2]), exp_mode(2, 2, 1));
    chk("R7", "fallback word 2", int'(lg_addr[1][5]), exp_mode(2, 2, 0));
  endtask

  task automatic test_mid_reset;
    for (int k = 0; k < 3000 && lg_n[0] < 3; k++) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check_reset_outputs("R11");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_done(0);
    check_order(0, "after reset");
    chk("R11", "restart spacing", lg_cyc[0][1] - lg_cyc[0][0], TRP);
    chk("R11", "restart settle", int'(low_cnt[0] >= STAB), 1);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL R9 watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    test_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    wait_done(0);
    wait_done(1);
    test_settle();
    check_order(0, "legal");
    test_banks();
    test_mode_words();
    test_spacing();
    test_done_hold();
    test_illegal();
    test_mid_reset();
    finish_run();
  end

endmodule